// File: doc/BRIEF.md
# Fractional Slot Rate Throttle

This block hands out a slot budget per stream at every packet boundary of a time-slotted link. Each stream is given a rate made of an integer part X and a fraction Y. Y is the fractional remainder of the rate multiplied by 2^FRAC_W and rounded up. Across many packets, the budgets of a stream average exactly X + Y/2^FRAC_W slots per packet. Four streams are handled by default, and each has its own rate register and its own fractional accumulator.

Software writes a new rate into a staging register for one stream. This raises a shared update-pending flag. The staged rate is not used straight away. It is taken over at the next packet boundary, because an update takes hundreds of nanoseconds to settle on the link and must not change a budget in the middle of a packet. When the rate is taken over, that stream's accumulator restarts from zero. The flag drops once every staged rate is in use. One cycle after each packet-start pulse, the block presents every stream's budget together with a one-cycle valid strobe.

Top module: `frt_throttle`

## Requirements
- R1: While reset is held and right after it, budget_vld, upd_pending and every budget field are 0. Rates and accumulators reset to 0.
- R2: A write (wr_en high) sets upd_pending from the next cycle on. upd_pending stays high until a packet-start pulse arrives.
- R3: At a pkt_start with a staged rate pending for a stream, the stream takes over that rate and its accumulator restarts from 0. The budget for that same packet equals the new X.
- R4: budget_vld is high for exactly one cycle, the cycle after each pkt_start, and is low at all other times. Every budget field reads 0 whenever budget_vld is low.
- R5: For the k-th packet since a rate was taken over, the budget is X + floor(k·Y/2^FRAC_W) − floor((k−1)·Y/2^FRAC_W). This is the carry out of a FRAC_W-bit accumulator that adds Y once per packet.
- R6: Over 2^FRAC_W consecutive packets starting at the one where a rate is taken over, the budgets of that stream sum to exactly X·2^FRAC_W + Y when no capping occurs.
- R7: A budget never exceeds BUDGET_CAP (64 by default). Any value above the cap is delivered as the cap.
- R8: A write or rate change for one stream leaves the budgets of all other streams unchanged. Stream n occupies budget bits [7n+6:7n] and is selected by wr_sel = n.
- R9: A pkt_start with no write in the same cycle leaves upd_pending low from the next cycle on. A write in the same cycle as pkt_start stays pending for the following boundary, and the packet itself uses the previously staged value.
- R10: With Y = 0 the budget equals X on every packet.
- R11: When several writes hit the same stream before a boundary, only the last one takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Rate write strobe |
| wr_sel | input | SEL_W | Stream selected by the write |
| wr_int | input | INT_W | Integer slots per packet (X) |
| wr_frac | input | FRAC_W | Fraction scaled by 2^FRAC_W (Y) |
| pkt_start | input | 1 | Packet boundary pulse |
| budget | output | NS*7 | Per-stream slot budgets, stream n at bits [7n+6:7n] |
| budget_vld | output | 1 | Budgets valid, one cycle after pkt_start |
| upd_pending | output | 1 | A staged rate is not yet in use |

## Verification
The assertions assume that pkt_start and wr_en are plain synchronous pulses, and that wr_sel names an existing stream whenever wr_en is high. The pending-clear property further assumes that a boundary without a concurrent write consumes every staged rate. The stimulus drives every input on the falling edge. It only ever selects streams 0 to 3, spaces boundaries by at least one idle cycle, and raises a write together with a boundary only in the one case built to test that collision. The bench reduces FRAC_W to 8, so that the full-period sum over 2^FRAC_W packets fits in a short run.

// File: rtl/frt_pkg.sv
package frt_pkg;
  parameter int DEF_STREAMS = 4;
  parameter int DEF_INT_W   = 7;
  parameter int DEF_FRAC_W  = 25;
  parameter int DEF_CAP     = 64;

  // width needed to hold values 0..v
  function automatic int width_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/frt_rate_bank.sv
module frt_rate_bank #(
  parameter int NS     = 4,
  parameter int INT_W  = 7,
  parameter int FRAC_W = 25,
  parameter int SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [INT_W-1:0]      wr_int,
  input  logic [FRAC_W-1:0]     wr_frac,
  input  logic                  pkt_start,
  output logic [NS*INT_W-1:0]   stage_x,
  output logic [NS*FRAC_W-1:0]  stage_y,
  output logic [NS-1:0]         apply,
  output logic                  pend_any
);
  logic [NS-1:0] pend_q;

  for (genvar i = 0; i < NS; i++) begin : g_stage
    logic             hit;
    logic [INT_W-1:0] x_q;
    logic [FRAC_W-1:0] y_q;

    assign hit = wr_en && (wr_sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        x_q       <= '0;
        y_q       <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (hit) begin
          x_q <= wr_int;
          y_q <= wr_frac;
        end
        // a write in a boundary cycle stays pending for the next boundary
        if (hit)
          pend_q[i] <= 1'b1;
        else if (pkt_start)
          pend_q[i] <= 1'b0;
      end
    end

    assign stage_x[i*INT_W +: INT_W]   = x_q;
    assign stage_y[i*FRAC_W +: FRAC_W] = y_q;
    assign apply[i]                    = pend_q[i] & pkt_start;
  end

  assign pend_any = |pend_q;
endmodule

// File: rtl/frt_lane.sv
module frt_lane #(
  parameter int INT_W  = 7,
  parameter int FRAC_W = 25,
  parameter int CAP    = 64,
  parameter int BUD_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_start,
  input  logic              apply,
  input  logic [INT_W-1:0]  new_x,
  input  logic [FRAC_W-1:0] new_y,
  output logic [BUD_W-1:0]  budget
);
  localparam int RAW_W = INT_W + 1;

  logic [INT_W-1:0]  act_x;
  logic [FRAC_W-1:0] act_y;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_nxt;
  logic [RAW_W-1:0]  raw;
  logic [31:0]       raw32;
  logic [BUD_W-1:0]  capped;

  always_comb begin
    sum = {1'b0, acc} + {1'b0, act_y};
    if (apply) begin
      // accumulator restarts from zero, then adds the new fraction once
      acc_nxt = new_y;
      raw     = {1'b0, new_x};
    end else begin
      acc_nxt = sum[FRAC_W-1:0];
      raw     = {1'b0, act_x} + RAW_W'(sum[FRAC_W]);
    end
    raw32  = 32'(raw);
    capped = (raw32 > 32'(CAP)) ? BUD_W'(CAP) : BUD_W'(raw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_x  <= '0;
      act_y  <= '0;
      acc    <= '0;
      budget <= '0;
    end else if (pkt_start) begin
      acc    <= acc_nxt;
      budget <= capped;
      if (apply) begin
        act_x <= new_x;
        act_y <= new_y;
      end
    end else begin
      budget <= '0;
    end
  end
endmodule

// File: rtl/frt_throttle.sv
module frt_throttle #(
  parameter int NS         = frt_pkg::DEF_STREAMS,
  parameter int INT_W      = frt_pkg::DEF_INT_W,
  parameter int FRAC_W     = frt_pkg::DEF_FRAC_W,
  parameter int BUDGET_CAP = frt_pkg::DEF_CAP,
  parameter int SEL_W      = frt_pkg::width_for(NS - 1),
  parameter int BUD_W      = frt_pkg::width_for(BUDGET_CAP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [INT_W-1:0]     wr_int,
  input  logic [FRAC_W-1:0]    wr_frac,
  input  logic                 pkt_start,
  output logic [NS*BUD_W-1:0]  budget,
  output logic                 budget_vld,
  output logic                 upd_pending
);
  logic [NS*INT_W-1:0]  stage_x;
  logic [NS*FRAC_W-1:0] stage_y;
  logic [NS-1:0]        apply;

  frt_rate_bank #(
    .NS(NS), .INT_W(INT_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_int(wr_int), .wr_frac(wr_frac),
    .pkt_start(pkt_start),
    .stage_x(stage_x), .stage_y(stage_y), .apply(apply),
    .pend_any(upd_pending)
  );

  for (genvar i = 0; i < NS; i++) begin : g_lane
    frt_lane #(
      .INT_W(INT_W), .FRAC_W(FRAC_W), .CAP(BUDGET_CAP), .BUD_W(BUD_W)
    ) u_lane (
      .clk(clk), .rst(rst),
      .pkt_start(pkt_start),
      .apply(apply[i]),
      .new_x(stage_x[i*INT_W +: INT_W]),
      .new_y(stage_y[i*FRAC_W +: FRAC_W]),
      .budget(budget[i*BUD_W +: BUD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) budget_vld <= 1'b0;
    else     budget_vld <= pkt_start;
  end
endmodule

// File: rtl/frt_throttle_chk.sv
module frt_throttle_chk #(
  parameter int NS    = 4,
  parameter int CAP   = 64,
  parameter int BUD_W = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                pkt_start,
  input logic [NS*BUD_W-1:0] budget,
  input logic                budget_vld,
  input logic                upd_pending
);
  AST_VLD_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> budget_vld); // R4
  AST_VLD_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    budget_vld |-> $past(pkt_start)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !budget_vld |-> (budget == '0)); // R4
  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> upd_pending); // R2
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (upd_pending && !pkt_start) |=> upd_pending); // R2
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && !wr_en) |=> !upd_pending); // R9

  for (genvar i = 0; i < NS; i++) begin : g_cap
    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (rst)
      budget_vld |-> (32'(budget[i*BUD_W +: BUD_W]) <= 32'(CAP))); // R7
  end
endmodule

bind frt_throttle frt_throttle_chk #(
  .NS(NS), .CAP(BUDGET_CAP), .BUD_W(BUD_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .pkt_start(pkt_start),
  .budget(budget), .budget_vld(budget_vld), .upd_pending(upd_pending)
);

// File: tb/tb_frt_throttle.sv
module tb_frt_throttle;
  localparam int NS = 4;
  localparam int IW = 7;
  localparam int F  = 8;
  localparam int BW = 7;
  localparam int CAPV = 64;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic [1:0]         wr_sel = '0;
  logic [IW-1:0]      wr_int = '0;
  logic [F-1:0]       wr_frac = '0;
  logic               pkt_start = 1'b0;
  logic [NS*BW-1:0]   budget;
  logic               budget_vld;
  logic               upd_pending;

  frt_throttle #(.NS(NS), .INT_W(IW), .FRAC_W(F), .BUDGET_CAP(CAPV)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_int(wr_int),
    .wr_frac(wr_frac), .pkt_start(pkt_start), .budget(budget),
    .budget_vld(budget_vld), .upd_pending(upd_pending)
  );

  always #10 clk = ~clk; // 50 MHz

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [NS*BW-1:0] exp_q[$];
  string            tag_q[$];

  // requirement model
  int    sx[NS], sy[NS], ax[NS], ay[NS];
  longint kc[NS];
  bit    mpend[NS];
  bit    sum_en = 1'b0;
  longint sum0 = 0;

  function automatic int expv(int x, int y, longint k);
    longint r;
    r = x + ((k * y) >> F) - (((k - 1) * y) >> F);
    return (r > CAPV) ? CAPV : int'(r);
  endfunction

  function automatic bit any_pend();
    for (int i = 0; i < NS; i++) if (mpend[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected budgets as the design produces them
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (budget_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected valid", 1, 0);
        end else begin
          logic [NS*BW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          for (int i = 0; i < NS; i++)
            check(budget[i*BW +: BW] == e[i*BW +: BW],
                  $sformatf("%s lane%0d", t, i),
                  budget[i*BW +: BW], e[i*BW +: BW]);
          if (sum_en) sum0 += budget[BW-1:0];
        end
      end else begin
        if (budget != '0) check(1'b0, "R4 idle budget nonzero", budget, 0);
      end
    end
  end

  task automatic wr(int sel, int x, int y, string tag);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_int = IW'(x); wr_frac = F'(y);
    @(negedge clk);
    wr_en = 1'b0;
    sx[sel] = x; sy[sel] = y; mpend[sel] = 1'b1;
    check(upd_pending == 1'b1, tag, upd_pending, 1);
  endtask

  task automatic push_packet(string tag);
    logic [NS*BW-1:0] e;
    for (int i = 0; i < NS; i++) begin
      if (mpend[i]) begin
        ax[i] = sx[i]; ay[i] = sy[i]; kc[i] = 0; mpend[i] = 1'b0;
      end
      kc[i]++;
      e[i*BW +: BW] = BW'(expv(ax[i], ay[i], kc[i]));
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // driver: one packet boundary, expected budgets pushed to the scoreboard
  task automatic pkt(string tag);
    push_packet(tag);
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    check(upd_pending == any_pend(), "R9 pending after boundary", upd_pending, any_pend());
    @(negedge clk);
  endtask

  task automatic pkt_wr(int sel, int x, int y, string tag);
    push_packet(tag);
    pkt_start = 1'b1;
    wr_en = 1'b1; wr_sel = 2'(sel); wr_int = IW'(x); wr_frac = F'(y);
    @(negedge clk);
    pkt_start = 1'b0; wr_en = 1'b0;
    sx[sel] = x; sy[sel] = y; mpend[sel] = 1'b1;
    check(upd_pending == 1'b1, "R9 coincident write stays pending", upd_pending, 1);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      sx[i] = 0; sy[i] = 0; ax[i] = 0; ay[i] = 0; kc[i] = 0; mpend[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(budget_vld == 1'b0, "R1 vld in reset", budget_vld, 0);
    check(upd_pending == 1'b0, "R1 pending in reset", upd_pending, 0);
    check(budget == '0, "R1 budget in reset", budget, 0);
    rst = 1'b0;
    @(negedge clk);
    check(upd_pending == 1'b0, "R1 pending after reset", upd_pending, 0);

    pkt("R4 zero rates");

    // R2: write, pending holds while idle
    wr(0, 5, 77, "R2 write sets pending");
    repeat (3) @(negedge clk);
    check(upd_pending == 1'b1, "R2 pending held", upd_pending, 1);

    // R3/R6: lane0 takes rate at this boundary; sum over 2^F packets
    sum_en = 1'b1;
    pkt("R3 new rate applied");
    wr(1, 3, 200, "R2 write lane1");
    wr(2, 10, 0, "R2 write lane2");
    pkt("R8 other lanes applied, lane0 unchanged");
    wr(3, 64, 128, "R2 write lane3");
    for (int n = 2; n < (1 << F); n++)
      pkt("R5 carry sequence / R7 cap / R10 zero fraction");
    sum_en = 1'b0;
    check(sum0 == longint'(5 * (1 << F) + 77), "R6 full-period sum",
          sum0, 5 * (1 << F) + 77);

    // R11: last write wins, and R7 cap on integer above cap
    wr(1, 20, 0, "R2 first write lane1");
    wr(1, 100, 0, "R11 second write lane1");
    pkt("R11 last write wins capped R7");

    // R9: write coincident with boundary
    pkt_wr(2, 7, 1, "R9 coincident packet uses old rate");
    pkt("R9 deferred write applied");
    pkt("R5 after deferred apply");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all budgets delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule